// File: doc/BRIEF.md
# Error-Diffusion Colour Depth Reducer

This block sits in front of a flat-panel column driver that accepts fewer than eight bits per colour. It takes one pixel per clock as three 8-bit channels (0 is darkest, 255 is brightest), together with active-low line and frame sync pulses and a strobe that is high on active pixels. It produces one pixel per clock with each channel cut to 3, 4, 5 or 6 significant bits. The rounding loss of each pixel is not discarded. It is pushed onto the pixel to the right and onto three pixels of the next line, so that area averages keep the original shade. In some modes a small offset is also added that rotates from frame to frame, so that the panel averages over time as well.

A 3-bit mode code chooses the output depth and whether the frame-to-frame offset is used. The result always fills the top of a 6-bit field per channel, and the bits below the chosen depth are zero. All timing comes from the sync and strobe inputs, so any line length up to the line-buffer parameter works. A bypass input forwards the top six input bits with the same one-cycle latency.

Top module: `gray_depth_reducer`

## Requirements
- R1: Mode codes 0, 1, 2 and 3 give 3, 4, 5 and 6 output bits with the frame offset on. Codes 5, 6 and 7 give 4, 5 and 6 bits with the frame offset off.
- R2: Each channel result is the quantised value shifted into the top of its 6-bit field. Field bits [2:0] are 0 at 3 bits, [1:0] at 4 bits and [0] at 5 bits.
- R3: The corrected value is the input plus floor((7·Eleft + Ebelow + Oframe)/16), clamped to 255. The output is its top B bits. The new error is the corrected value modulo 2^(8−B).
- R4: The error E of the pixel at column x goes to the next line in the shares 3E to column x−1, 5E to column x and 1E to column x+1. These are held in a line buffer of LB_DEPTH entries, and a column at or past LB_DEPTH reads 0. When the strobe falls, the pending sum for the last column is written.
- R5: The right-hand carry and the pending next-line sums are zero on every cycle with the strobe low, and on a falling edge of line sync. The column counter restarts at 0 on a falling edge of line sync.
- R6: A falling edge of frame sync empties the line buffer, zeroes the line counter and advances a 2-bit frame counter. The line counter advances on each falling edge of the strobe.
- R7: With the frame offset on, Oframe = ((F + x + y) mod 4) << (7 − (B − 3)). Here F is the frame counter, x is the column and y is the line counter mod 4. With it off, Oframe is 0.
- R8: With bypass high, each channel output equals input bits [7:2], one cycle later.
- R9: Mode code 4 is reserved and drives all channel outputs to 0, unless bypass is high.
- R10: The sync and strobe outputs equal their inputs one cycle earlier. All channel outputs are 0 on a cycle after a low strobe.
- R11: During reset the sync outputs are high, the strobe output is low and all channel outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Depth and diffusion mode code |
| bypass_i | input | 1 | Forward input bits [7:2] unprocessed |
| hsync_n_i | input | 1 | Line sync, active low |
| vsync_n_i | input | 1 | Frame sync, active low |
| valid_i | input | 1 | High on active pixels |
| red_i | input | 8 | Red sample |
| grn_i | input | 8 | Green sample |
| blu_i | input | 8 | Blue sample |
| hsync_n_o | output | 1 | Delayed line sync |
| vsync_n_o | output | 1 | Delayed frame sync |
| valid_o | output | 1 | Delayed active strobe |
| red_o | output | 6 | Red result field |
| grn_o | output | 6 | Green result field |
| blu_o | output | 6 | Blue result field |

## Verification
On every clock, properties check the field-alignment zeros in the 3-bit and 5-bit modes and the zero output of the reserved code. They also check the bypass copy, the blanking zeros, the sync follow-through and the emptying of the line buffer on frame start. The actual shade values depend on the error history across pixels, lines and frames. Only the bench's reference model can show them, over frames with extreme and constant pixels, broken strobes and several frames in a row.

// File: rtl/gdr_pkg.sv
package gdr_pkg;
    localparam int unsigned PIX_W     = 8;
    localparam int unsigned FIELD_W   = 6;
    localparam int unsigned MIN_OUT_W = 3;
    localparam int unsigned NCH       = 3;
    localparam int unsigned FRAC_W    = 4;
    localparam int unsigned ERR_W     = PIX_W - MIN_OUT_W;
    localparam int unsigned NL_W      = ERR_W + 4;
    localparam int unsigned TOT_W     = PIX_W + FRAC_W + 2;
    localparam int unsigned OFS_BASE  = FRAC_W + PIX_W - MIN_OUT_W - 2;

    typedef enum logic [2:0] {
        MD_D3_TF = 3'd0,
        MD_D4_TF = 3'd1,
        MD_D5_TF = 3'd2,
        MD_D6_TF = 3'd3,
        MD_RSVD  = 3'd4,
        MD_D4    = 3'd5,
        MD_D5    = 3'd6,
        MD_D6    = 3'd7
    } gdr_mode_e;
endpackage

// File: rtl/gdr_mode_decode.sv
module gdr_mode_decode
    import gdr_pkg::*;
(
    input  logic [2:0] mode_i,
    output logic [1:0] dsel_o,
    output logic       frame_en_o,
    output logic       reserved_o
);
    always_comb begin
        dsel_o     = 2'd3;
        frame_en_o = 1'b0;
        reserved_o = 1'b0;
        case (gdr_mode_e'(mode_i))
            MD_D3_TF: begin dsel_o = 2'd0; frame_en_o = 1'b1; end
            MD_D4_TF: begin dsel_o = 2'd1; frame_en_o = 1'b1; end
            MD_D5_TF: begin dsel_o = 2'd2; frame_en_o = 1'b1; end
            MD_D6_TF: begin dsel_o = 2'd3; frame_en_o = 1'b1; end
            MD_D4:    dsel_o = 2'd1;
            MD_D5:    dsel_o = 2'd2;
            MD_D6:    dsel_o = 2'd3;
            default:  reserved_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/gdr_quant.sv
module gdr_quant
    import gdr_pkg::*;
(
    input  logic [PIX_W-1:0]   pix_i,
    input  logic [ERR_W-1:0]   left_i,
    input  logic [NL_W-1:0]    below_i,
    input  logic [TOT_W-1:0]   ofs_i,
    input  logic [1:0]         dsel_i,
    output logic [FIELD_W-1:0] field_o,
    output logic [ERR_W-1:0]   err_o
);
    localparam int unsigned WHOLE_W = TOT_W - FRAC_W;
    localparam int unsigned EW1     = ERR_W + 1;
    localparam int unsigned LOW_MAX = FIELD_W - MIN_OUT_W;

    logic [TOT_W-1:0]   total;
    logic [WHOLE_W-1:0] whole;
    logic [PIX_W-1:0]   corr;
    logic [FIELD_W-1:0] low_mask;
    logic [EW1-1:0]     err_mask;

    always_comb begin
        total = (TOT_W'(pix_i) << FRAC_W)
              + TOT_W'(left_i) * TOT_W'(7)
              + TOT_W'(below_i)
              + ofs_i;
        whole = total[TOT_W-1:FRAC_W];
        if (whole > WHOLE_W'((1 << PIX_W) - 1)) begin
            corr = '1;
        end else begin
            corr = whole[PIX_W-1:0];
        end
        low_mask = (FIELD_W'(1) << (3'(LOW_MAX) - {1'b0, dsel_i})) - FIELD_W'(1);
        err_mask = (EW1'(1) << (3'(ERR_W) - {1'b0, dsel_i})) - EW1'(1);
        field_o  = corr[PIX_W-1:PIX_W-FIELD_W] & ~low_mask;
        err_o    = corr[ERR_W-1:0] & err_mask[ERR_W-1:0];
    end
endmodule

// File: rtl/gdr_linebuf.sv
module gdr_linebuf #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned W     = 27,
    parameter int unsigned AW    = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic [AW-1:0] rd_addr_i,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [W-1:0]  wr_data_i,
    output logic [W-1:0]  rd_data_o
);
    localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0][W-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (clr_i) begin
            mem_d = '0;
        end else if (wr_en_i && (wr_addr_i < AW'(DEPTH))) begin
            mem_d[IW'(wr_addr_i)] = wr_data_i;
        end
        if (rd_addr_i < AW'(DEPTH)) begin
            rd_data_o = mem_q[IW'(rd_addr_i)];
        end else begin
            rd_data_o = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    // R6: after a frame-start clear every location reads zero
    a_r6_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (rd_data_o == '0));
endmodule

// File: rtl/gray_depth_reducer.sv
module gray_depth_reducer
    import gdr_pkg::*;
#(
    parameter int unsigned LB_DEPTH = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         mode_i,
    input  logic               bypass_i,
    input  logic               hsync_n_i,
    input  logic               vsync_n_i,
    input  logic               valid_i,
    input  logic [PIX_W-1:0]   red_i,
    input  logic [PIX_W-1:0]   grn_i,
    input  logic [PIX_W-1:0]   blu_i,
    output logic               hsync_n_o,
    output logic               vsync_n_o,
    output logic               valid_o,
    output logic [FIELD_W-1:0] red_o,
    output logic [FIELD_W-1:0] grn_o,
    output logic [FIELD_W-1:0] blu_o
);
    localparam int unsigned XW = $clog2(LB_DEPTH + 1);
    localparam int unsigned LB_W = NCH * NL_W;

    typedef struct packed {
        logic                          hs;
        logic                          vs;
        logic                          vld;
        logic [XW-1:0]                 x;
        logic [1:0]                    y;
        logic [1:0]                    fc;
        logic [NCH-1:0][ERR_W-1:0]     ep;
        logic [NCH-1:0][NL_W-1:0]      am1;
        logic [NCH-1:0][NL_W-1:0]      a0;
        logic [NCH-1:0][FIELD_W-1:0]   dat;
    } gdr_state_t;

    gdr_state_t state_d, state_q;

    logic [NCH-1:0][PIX_W-1:0]   pix;
    logic [1:0]                  dsel;
    logic                        frame_en, reserved;
    logic                        hs_fall, vs_fall, v_fall;
    logic [XW-1:0]               x_use;
    logic [1:0]                  phase;
    logic [TOT_W-1:0]            ofs;
    logic [NCH-1:0][ERR_W-1:0]   ep_e;
    logic [NCH-1:0][NL_W-1:0]    am1_e, a0_e;
    logic [NCH-1:0][NL_W-1:0]    below;
    logic [NCH-1:0][FIELD_W-1:0] fld;
    logic [NCH-1:0][ERR_W-1:0]   err;
    logic                        lb_clr, lb_wr_en;
    logic [XW-1:0]               lb_wr_addr;
    logic [NCH-1:0][NL_W-1:0]    lb_wr_data;

    assign pix = {blu_i, grn_i, red_i};

    gdr_mode_decode u_decode (
        .mode_i     (mode_i),
        .dsel_o     (dsel),
        .frame_en_o (frame_en),
        .reserved_o (reserved)
    );

    // sync edges and per-pixel context
    always_comb begin
        hs_fall = state_q.hs & ~hsync_n_i;
        vs_fall = state_q.vs & ~vsync_n_i;
        v_fall  = state_q.vld & ~valid_i;
        x_use   = hs_fall ? '0 : state_q.x;
        phase   = state_q.fc + x_use[1:0] + state_q.y;
        ofs     = frame_en ? (TOT_W'(phase) << (3'(OFS_BASE) - {1'b0, dsel})) : '0;
        ep_e    = hs_fall ? '0 : state_q.ep;
        am1_e   = hs_fall ? '0 : state_q.am1;
        a0_e    = hs_fall ? '0 : state_q.a0;
    end

    gdr_linebuf #(
        .DEPTH (LB_DEPTH),
        .W     (LB_W),
        .AW    (XW)
    ) u_linebuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (lb_clr),
        .rd_addr_i (x_use),
        .wr_en_i   (lb_wr_en),
        .wr_addr_i (lb_wr_addr),
        .wr_data_i (lb_wr_data),
        .rd_data_o (below)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        gdr_quant u_quant (
            .pix_i   (pix[c]),
            .left_i  (ep_e[c]),
            .below_i (below[c]),
            .ofs_i   (ofs),
            .dsel_i  (dsel),
            .field_o (fld[c]),
            .err_o   (err[c])
        );
    end

    always_comb begin
        state_d    = state_q;
        lb_clr     = vs_fall;
        lb_wr_en   = 1'b0;
        lb_wr_addr = x_use - XW'(1);
        lb_wr_data = '0;
        if (valid_i) begin
            lb_wr_en = (x_use != '0);
            for (int c = 0; c < NCH; c++) begin
                lb_wr_data[c]   = am1_e[c] + NL_W'(err[c]) * NL_W'(3);
                state_d.am1[c]  = a0_e[c] + NL_W'(err[c]) * NL_W'(5);
                state_d.a0[c]   = NL_W'(err[c]);
                state_d.ep[c]   = err[c];
                if (bypass_i) begin
                    state_d.dat[c] = pix[c][PIX_W-1:PIX_W-FIELD_W];
                end else if (reserved) begin
                    state_d.dat[c] = '0;
                end else begin
                    state_d.dat[c] = fld[c];
                end
            end
            state_d.x = (x_use == XW'(LB_DEPTH)) ? x_use : x_use + XW'(1);
        end else begin
            if (v_fall && (state_q.x != '0)) begin
                lb_wr_en   = 1'b1;
                lb_wr_addr = state_q.x - XW'(1);
                lb_wr_data = state_q.am1;
            end
            if (v_fall) begin
                state_d.y = state_q.y + 2'd1;
            end
            state_d.ep  = '0;
            state_d.am1 = '0;
            state_d.a0  = '0;
            state_d.dat = '0;
            state_d.x   = x_use;
        end
        if (vs_fall) begin
            state_d.y  = '0;
            state_d.fc = state_q.fc + 2'd1;
        end
        state_d.hs  = hsync_n_i;
        state_d.vs  = vsync_n_i;
        state_d.vld = valid_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= '0;
            state_q.hs <= 1'b1;
            state_q.vs <= 1'b1;
        end else begin
            state_q <= state_d;
        end
    end

    assign hsync_n_o = state_q.hs;
    assign vsync_n_o = state_q.vs;
    assign valid_o   = state_q.vld;
    assign red_o     = state_q.dat[0];
    assign grn_o     = state_q.dat[1];
    assign blu_o     = state_q.dat[2];

    // R2: 3-bit results leave the three low field bits clear
    a_r2_three_bit_low: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !bypass_i && mode_i == 3'd0)
        |=> (red_o[2:0] == 3'd0 && grn_o[2:0] == 3'd0 && blu_o[2:0] == 3'd0));

    // R2: 5-bit results leave the lowest field bit clear
    a_r2_five_bit_low: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !bypass_i && (mode_i == 3'd2 || mode_i == 3'd6))
        |=> (red_o[0] == 1'b0 && grn_o[0] == 1'b0 && blu_o[0] == 1'b0));

    // R8: bypass forwards the top six input bits one cycle later
    a_r8_bypass_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && bypass_i)
        |=> (red_o == $past(red_i[7:2]) && grn_o == $past(grn_i[7:2])
             && blu_o == $past(blu_i[7:2])));

    // R9: reserved code blanks the data
    a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !bypass_i && mode_i == 3'd4)
        |=> (red_o == '0 && grn_o == '0 && blu_o == '0));

    // R10: no data during blanking
    a_r10_blank_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> (red_o == '0 && grn_o == '0 && blu_o == '0 && !valid_o));

    // R10: syncs follow their inputs with one cycle of delay
    a_r10_hsync_follow: assert property (@(posedge clk) disable iff (!rst_n)
        !hsync_n_i |=> !hsync_n_o);
    a_r10_vsync_follow: assert property (@(posedge clk) disable iff (!rst_n)
        !vsync_n_i |=> !vsync_n_o);
endmodule

// File: tb/gray_depth_reducer_bench.sv
module gray_depth_reducer_bench;
    localparam int LBD = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode = 3'd0;
    logic       bypass = 1'b0;
    logic       hsync_n = 1'b1, vsync_n = 1'b1, valid = 1'b0;
    logic [7:0] red = 8'd0, grn = 8'd0, blu = 8'd0;
    logic       hsync_n_o, vsync_n_o, valid_o;
    logic [5:0] red_o, grn_o, blu_o;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    string tag = "R11";

    always #4 clk = ~clk;

    gray_depth_reducer #(.LB_DEPTH(LBD)) u_gray_depth_reducer (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .bypass_i(bypass),
        .hsync_n_i(hsync_n), .vsync_n_i(vsync_n), .valid_i(valid),
        .red_i(red), .grn_i(grn), .blu_i(blu),
        .hsync_n_o(hsync_n_o), .vsync_n_o(vsync_n_o), .valid_o(valid_o),
        .red_o(red_o), .grn_o(grn_o), .blu_o(blu_o)
    );

    // behavioural reference state
    int lb [3][LBD];
    int ep [3];
    int am1 [3];
    int a0 [3];
    int mx, my, mfc;
    bit hp, vp, vldp;
    int e_dat [3];
    bit e_hs, e_vs, e_v;

    function automatic int depth_of(input int md);
        case (md)
            0: return 3;
            1: return 4;
            2: return 5;
            5: return 4;
            6: return 5;
            default: return 6;
        endcase
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < 3; c++) begin
            ep[c] = 0; am1[c] = 0; a0[c] = 0; e_dat[c] = 0;
            for (int i = 0; i < LBD; i++) lb[c][i] = 0;
        end
        mx = 0; my = 0; mfc = 0;
        hp = 1; vp = 1; vldp = 0;
        e_hs = 1; e_vs = 1; e_v = 0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            model_reset();
        end else begin
            bit hsf, vsf, vf, fe;
            int xu, b, step, ofs;
            int p [3];
            p[0] = int'(red); p[1] = int'(grn); p[2] = int'(blu);
            hsf = hp && !hsync_n;
            vsf = vp && !vsync_n;
            vf  = vldp && !valid;
            xu  = hsf ? 0 : mx;
            b   = depth_of(int'(mode));
            step = 1 << (8 - b);
            fe  = (mode < 3'd4);
            ofs = fe ? (((mfc + xu + my) % 4) * step * 4) : 0;
            if (valid) begin
                for (int c = 0; c < 3; c++) begin
                    int l, a1, az, bl, tot, cv, e, fld;
                    l  = hsf ? 0 : ep[c];
                    a1 = hsf ? 0 : am1[c];
                    az = hsf ? 0 : a0[c];
                    bl = (xu < LBD) ? lb[c][xu] : 0;
                    tot = 16 * p[c] + 7 * l + bl + ofs;
                    cv = tot / 16;
                    if (cv > 255) cv = 255;
                    e = cv % step;
                    fld = (cv / step) * (1 << (6 - b));
                    if (xu > 0) lb[c][xu - 1] = a1 + 3 * e;
                    am1[c] = az + 5 * e;
                    a0[c]  = e;
                    ep[c]  = e;
                    if (bypass) e_dat[c] = p[c] / 4;
                    else if (mode == 3'd4) e_dat[c] = 0;
                    else e_dat[c] = fld;
                end
                mx = (xu == LBD) ? xu : xu + 1;
            end else begin
                if (vf && mx > 0) begin
                    for (int c = 0; c < 3; c++) lb[c][mx - 1] = am1[c];
                end
                if (vf) my = (my + 1) % 4;
                for (int c = 0; c < 3; c++) begin
                    ep[c] = 0; am1[c] = 0; a0[c] = 0; e_dat[c] = 0;
                end
                mx = xu;
            end
            if (vsf) begin
                for (int c = 0; c < 3; c++)
                    for (int i = 0; i < LBD; i++) lb[c][i] = 0;
                my = 0;
                mfc = (mfc + 1) % 4;
            end
            hp = hsync_n; vp = vsync_n; vldp = valid;
            e_hs = hsync_n; e_vs = vsync_n; e_v = valid;
        end
        #2;
        begin
            string rq;
            rq = rst_n ? tag : "R11";
            check(rst_n ? "R10" : "R11", "hsync", int'(hsync_n_o), int'(e_hs));
            check(rst_n ? "R10" : "R11", "vsync", int'(vsync_n_o), int'(e_vs));
            check(rst_n ? "R10" : "R11", "valid", int'(valid_o), int'(e_v));
            check(rq, "red", int'(red_o), e_dat[0]);
            check(rq, "grn", int'(grn_o), e_dat[1]);
            check(rq, "blu", int'(blu_o), e_dat[2]);
        end
    end

    function automatic logic [7:0] pick(input int pat, input int n, input int c);
        case (pat)
            1: return 8'd100 + 8'(c * 37);
            2: return 8'd255;
            3: return 8'd0;
            default: begin
                if (n % 7 == 3) return 8'd255;
                if (n % 11 == 5) return 8'd0;
                return 8'($urandom_range(0, 255));
            end
        endcase
    endfunction

    task automatic run_frame(input int md, input bit byp, input int nl, input int np,
                             input int pat, input bit gaps);
        int n = 0;
        @(negedge clk);
        mode = 3'(md); bypass = byp;
        vsync_n = 1'b0; hsync_n = 1'b0;
        repeat (2) @(negedge clk);
        vsync_n = 1'b1; hsync_n = 1'b1;
        repeat (2) @(negedge clk);
        for (int ln = 0; ln < nl; ln++) begin
            hsync_n = 1'b0;
            repeat (2) @(negedge clk);
            hsync_n = 1'b1;
            repeat (2) @(negedge clk);
            for (int px = 0; px < np; px++) begin
                if (gaps && px == np / 2) begin
                    valid = 1'b0; red = 0; grn = 0; blu = 0;
                    repeat (2) @(negedge clk);
                end
                valid = 1'b1;
                red = pick(pat, n, 0); grn = pick(pat, n, 1); blu = pick(pat, n, 2);
                n++;
                @(negedge clk);
            end
            valid = 1'b0; red = 0; grn = 0; blu = 0;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cycles > 100000) begin
            n_cmp++; n_bad++;
            $display("FAIL R10 watchdog actual=%0d expected<100000 cycles", cycles);
            finish_run();
        end
    end

    initial begin
        tag = "R11";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tag = "R2";  run_frame(0, 0, 4, 12, 0, 0);   // R2 3-bit alignment
        tag = "R1";  run_frame(3, 0, 3, 10, 0, 0);   // R1 6-bit with frame offset
        tag = "R1";  run_frame(2, 0, 3, 10, 1, 0);   // R1 5-bit with frame offset
        tag = "R3";  run_frame(7, 0, 4, 14, 0, 0);   // R3 extremes and saturation
        tag = "R3";  run_frame(0, 0, 2, 8, 2, 0);    // R3 full-scale input clamps
        tag = "R4";  run_frame(6, 0, 5, 12, 1, 0);   // R4 constant shade spreads
        tag = "R5";  run_frame(5, 0, 4, 12, 0, 1);   // R5 strobe gaps mid-line
        tag = "R6";  run_frame(5, 0, 3, 10, 1, 0);   // R6 buffer restarts per frame
        tag = "R6";  run_frame(5, 0, 3, 10, 1, 0);
        tag = "R7";  run_frame(1, 0, 3, 9, 1, 0);    // R7 offset rotates with frames
        tag = "R7";  run_frame(1, 0, 3, 9, 1, 0);
        tag = "R7";  run_frame(0, 0, 3, 9, 3, 0);
        tag = "R8";  run_frame(1, 1, 2, 10, 0, 0);   // R8 bypass
        tag = "R9";  run_frame(4, 0, 2, 10, 0, 0);   // R9 reserved code
        tag = "R10"; run_frame(3, 0, 2, 6, 0, 1);    // R10 blanking and sync delay
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule